// File: doc/BRIEF.md
# Prescaled Timer Bank with Atomic Capture

This block holds three 16-bit up-counters for a peripheral controller. Each counter has its own prescaler and its own top-compare value. A counter climbs from zero to its top value and then falls back to zero. Every fall back to zero is a wrap. Each wrap flips that timer's toggle output and can raise the timer's interrupt flag. A timer can count system clock cycles, or, for timers 0 and 1 only, rising edges seen on an external clock pin. Either way, the prescaler divides the events before they reach the counter.

The host side works through write strobes. The bus logic assembles each 16-bit value before it arrives here. One strobe sets the options, which are the per-timer interrupt enables and the external-source selects. Another clears flags with write-one-to-clear semantics. A third strobe is the capture command. It copies all three running counters into the capture outputs on one clock edge, so software can read a consistent set of values. The three flags are also ORed into a single interrupt line.

Top module: `tmr_bank`

## Requirements
- R1: The reset state is as follows: toggles low, flags low, interrupt low, capture values zero, counters and prescale counts zero, prescale values zero, top values 16'hFFFF, interrupt enables off and external selects off. The internal reset releases on the second clock edge after `rst_n` rises, and the timers first count on the third edge.
- R2: Each prescaler tick adds one to the counter. On a tick where the counter equals its top value, the counter becomes zero instead; this is a wrap. Past 16'hFFFF the counter rolls to zero without a wrap.
- R3: With prescale value P, the counter ticks once for every P+1 count events. For a system-clock source, one count event is one clock cycle.
- R4: `opt_we` loads `irq_en_in` and `ext_sel_in`. When `ext_sel_in[i]` is set for timer i (i = 0 or 1), the count events for that timer are rising edges on `ext_clk[i]`. The pin passes through a two-flop synchronizer, and a rise is counted three clock edges after the pin changes. Timer 2 always counts system clocks.
- R5: Each wrap inverts that timer's `tgl_out` bit on the same edge.
- R6: A wrap sets the timer's `irq_flags` bit when its enable is on, where the enable is the value being written on that edge if `opt_we` is high. A set in the same cycle as a clear of the same bit wins.
- R7: A write with `irq_clr_we` clears every flag whose bit in `irq_clr_mask` is one. Flags under zero mask bits are unchanged.
- R8: Loading an interrupt enable bit as zero clears that timer's flag on the same edge.
- R9: `capt_we` copies all three counter values, as they stand in the cycle of the strobe, into `cap_val` (timer i at bits [16i+15:16i]). The capture values do not change otherwise.
- R10: `cnt_we[i]` or `pre_we[i]` loads `wr_data` into the counter or prescale value of timer i on the next edge and restarts that timer's prescale count from zero. No tick happens on that edge. `top_we[i]` loads the top value, and the old value is still used for the compare on that edge.
- R11: `irq_any` is high exactly when at least one flag in `irq_flags` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 16 | Shared 16-bit write value |
| cnt_we | input | 3 | Per-timer counter load strobe |
| pre_we | input | 3 | Per-timer prescale value load strobe |
| top_we | input | 3 | Per-timer top value load strobe |
| opt_we | input | 1 | Load strobe for enables and source selects |
| irq_en_in | input | 3 | Interrupt enable values to load |
| ext_sel_in | input | 2 | External source select values for timers 0 and 1 |
| irq_clr_we | input | 1 | Flag clear strobe |
| irq_clr_mask | input | 3 | Flags to clear, one bit per timer |
| capt_we | input | 1 | Capture command |
| ext_clk | input | 2 | External count pins for timers 0 and 1 |
| tgl_out | output | 3 | Per-timer toggle outputs |
| cap_val | output | 48 | Captured counter values, timer i at [16i+15:16i] |
| irq_flags | output | 3 | Per-timer interrupt flags |
| irq_any | output | 1 | OR of all flags |

## Verification
The bench targets the following corner cases; the expected failure for each is in brackets.
- A counter load or prescale load landing between two prescaler ticks. [A design that keeps the old prescale count ticks early.]
- A top value reached exactly. [An off-by-one compare makes the wrap period one tick too long or too short.]
- A flag clear or an enable drop arriving on the same edge as a wrap. [A wrong priority drops an interrupt, or leaves a stale flag after the enable is turned off.]
- External pulses counted through the synchronizer. [A missing edge detector counts every high cycle.]
- Captures taken while the counters run. [A non-atomic copy would show values from different cycles.]

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int TMR_NUM = 3;
  parameter int TMR_EXT = 2;
  parameter int TMR_W   = 16;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic         cnt_we,
  input  logic         pre_we,
  input  logic         top_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic         wrap,
  output logic         tgl
);
  logic [W-1:0] pre_q, top_q, cnt_q, pcnt_q;
  logic [W-1:0] cnt_n, pcnt_n;
  logic         tgl_q, tick;
  logic         cnt_ld, pcnt_ld;

  always_comb begin
    pcnt_n = pcnt_q;
    tick   = 1'b0;
    if (cnt_we || pre_we) begin
      pcnt_n = '0;
    end else if (evt) begin
      if (pcnt_q == pre_q) begin
        pcnt_n = '0;
        tick   = 1'b1;
      end else begin
        pcnt_n = pcnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    cnt_n = cnt_q;
    wrap  = 1'b0;
    if (cnt_we) begin
      cnt_n = wdata;
    end else if (tick) begin
      if (cnt_q == top_q) begin
        cnt_n = '0;
        wrap  = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  assign cnt_ld  = cnt_we | tick;
  assign pcnt_ld = cnt_we | pre_we | evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      top_q  <= '1;
      cnt_q  <= '0;
      pcnt_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      if (pre_we)  pre_q  <= wdata;
      if (top_we)  top_q  <= wdata;
      if (cnt_ld)  cnt_q  <= cnt_n;
      if (pcnt_ld) pcnt_q <= pcnt_n;
      if (wrap)    tgl_q  <= ~tgl_q;
    end
  end

  assign cnt = cnt_q;
  assign tgl = tgl_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] en_d,
  input  logic [N-1:0] wrap,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_q, flag_n, clr_v;

  assign clr_v = clr_we ? clr_mask : '0;

  always_comb begin
    flag_n = en_d & (wrap | (flag_q & ~clr_v));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_n;
  end

  assign flags = flag_q;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NUM = TMR_NUM,
  parameter int NEXT = TMR_EXT,
  parameter int W = TMR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     wr_data,
  input  logic [NUM-1:0]   cnt_we,
  input  logic [NUM-1:0]   pre_we,
  input  logic [NUM-1:0]   top_we,
  input  logic             opt_we,
  input  logic [NUM-1:0]   irq_en_in,
  input  logic [NEXT-1:0]  ext_sel_in,
  input  logic             irq_clr_we,
  input  logic [NUM-1:0]   irq_clr_mask,
  input  logic             capt_we,
  input  logic [NEXT-1:0]  ext_clk,
  output logic [NUM-1:0]   tgl_out,
  output logic [NUM*W-1:0] cap_val,
  output logic [NUM-1:0]   irq_flags,
  output logic             irq_any
);
  localparam int CAPW = NUM * W;

  logic            rst_a_q, rst_b_q, rst_i;
  logic [NUM-1:0]  en_q, en_d, evt, wrap;
  logic [NEXT-1:0] ext_q, rise;
  logic [CAPW-1:0] cnt_all, cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_b_q <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_b_q <= rst_a_q;
    end
  end
  assign rst_i = rst_b_q;

  assign en_d = opt_we ? irq_en_in : en_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      en_q  <= '0;
      ext_q <= '0;
      cap_q <= '0;
    end else begin
      if (opt_we) begin
        en_q  <= irq_en_in;
        ext_q <= ext_sel_in;
      end
      if (capt_we) cap_q <= cnt_all;
    end
  end

  for (genvar g = 0; g < NUM; g++) begin : g_tmr
    if (g < NEXT) begin : g_ext
      tmr_edge_sync u_sync (
        .clk  (clk),
        .rst_n(rst_i),
        .pin  (ext_clk[g]),
        .rise (rise[g])
      );
      assign evt[g] = ext_q[g] ? rise[g] : 1'b1;
    end else begin : g_sys
      assign evt[g] = 1'b1;
    end

    tmr_channel #(.W(W)) u_ch (
      .clk   (clk),
      .rst_n (rst_i),
      .evt   (evt[g]),
      .cnt_we(cnt_we[g]),
      .pre_we(pre_we[g]),
      .top_we(top_we[g]),
      .wdata (wr_data),
      .cnt   (cnt_all[g*W +: W]),
      .wrap  (wrap[g]),
      .tgl   (tgl_out[g])
    );
  end

  tmr_irq #(.N(NUM)) u_irq (
    .clk     (clk),
    .rst_n   (rst_i),
    .en_d    (en_d),
    .wrap    (wrap),
    .clr_we  (irq_clr_we),
    .clr_mask(irq_clr_mask),
    .flags   (irq_flags)
  );

  assign cap_val = cap_q;
  assign irq_any = |irq_flags;
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int NUM = 3,
  parameter int NEXT = 2,
  parameter int W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             opt_we,
  input logic [NUM-1:0]   irq_en_in,
  input logic             capt_we,
  input logic [NUM-1:0]   tgl_out,
  input logic [NUM*W-1:0] cap_val,
  input logic [NUM-1:0]   irq_flags,
  input logic             irq_any
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (tgl_out == '0 && irq_flags == '0 && !irq_any);
    end
  end

  assert_cap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !capt_we |=> $stable(cap_val));

  for (genvar g = 0; g < NUM; g++) begin : g_chk
    assert_flag_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (opt_we && !irq_en_in[g]) |=> !irq_flags[g]);

    assert_flag_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flags[g]) |-> (tgl_out[g] != $past(tgl_out[g])));
  end

  assert_any_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> ($countones(irq_flags) != 0));
endmodule

bind tmr_bank tmr_bank_chk #(.NUM(NUM), .NEXT(NEXT), .W(W)) u_chk (.*);

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb;
  localparam int N = 3;
  localparam int NE = 2;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [W-1:0]   wr_data = '0;
  logic [N-1:0]   cnt_we = '0, pre_we = '0, top_we = '0;
  logic           opt_we = 1'b0;
  logic [N-1:0]   irq_en_in = '0;
  logic [NE-1:0]  ext_sel_in = '0;
  logic           irq_clr_we = 1'b0;
  logic [N-1:0]   irq_clr_mask = '0;
  logic           capt_we = 1'b0;
  logic [NE-1:0]  ext_clk = '0;
  logic [N-1:0]   tgl_out, irq_flags;
  logic [N*W-1:0] cap_val;
  logic           irq_any;

  int nchk = 0;
  int nfail = 0;
  int wd = 0;

  always #2.5 clk = ~clk;

  tmr_bank u_dut (.*);

  // bench-side reference state
  logic [W-1:0] m_pre[N], m_top[N], m_cnt[N], m_pc[N], m_cap[N];
  logic [N-1:0] m_tgl, m_flag, m_en;
  logic [NE-1:0] m_ext, m_a, m_b, m_c;
  int m_rc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rc = 0;
      for (int i = 0; i < N; i++) begin
        m_pre[i] = '0; m_top[i] = '1; m_cnt[i] = '0; m_pc[i] = '0; m_cap[i] = '0;
      end
      m_tgl = '0; m_flag = '0; m_en = '0; m_ext = '0; m_a = '0; m_b = '0; m_c = '0;
    end else if (m_rc < 2) begin
      m_rc++;
    end else begin
      logic [NE-1:0] edge_v;
      logic [N-1:0]  en_new, wrp, clr;
      edge_v = m_b & ~m_c;
      en_new = opt_we ? irq_en_in : m_en;
      clr = irq_clr_we ? irq_clr_mask : '0;
      if (capt_we) for (int i = 0; i < N; i++) m_cap[i] = m_cnt[i];
      for (int i = 0; i < N; i++) begin
        logic ev, tk;
        ev = (i < NE && m_ext[i]) ? edge_v[i] : 1'b1;
        tk = 1'b0;
        wrp[i] = 1'b0;
        if (cnt_we[i] || pre_we[i]) m_pc[i] = '0;
        else if (ev) begin
          if (m_pc[i] == m_pre[i]) begin m_pc[i] = '0; tk = 1'b1; end
          else m_pc[i] = m_pc[i] + 1'b1;
        end
        if (cnt_we[i]) m_cnt[i] = wr_data;
        else if (tk) begin
          if (m_cnt[i] == m_top[i]) begin m_cnt[i] = '0; wrp[i] = 1'b1; end
          else m_cnt[i] = m_cnt[i] + 1'b1;
        end
        if (pre_we[i]) m_pre[i] = wr_data;
        if (top_we[i]) m_top[i] = wr_data;
      end
      m_tgl = m_tgl ^ wrp;
      m_flag = en_new & (wrp | (m_flag & ~clr));
      m_en = en_new;
      if (opt_we) m_ext = ext_sel_in;
      m_c = m_b; m_b = m_a; m_a = ext_clk;
    end
  end

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "tgl_out", W'(tgl_out), W'(m_tgl));
    chk(tag, "irq_flags", W'(irq_flags), W'(m_flag));
    chk(tag, "irq_any", W'(irq_any), W'(|m_flag));
    for (int i = 0; i < N; i++) chk(tag, "cap_val", cap_val[i*W +: W], m_cap[i]);
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    cnt_we = '0; pre_we = '0; top_we = '0; opt_we = 1'b0;
    irq_clr_we = 1'b0; capt_we = 1'b0;
  endtask

  task automatic run(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      capt_we = 1'b1;
      step(tag);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int s;
    s = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
    step("R1");
    step("R1");
    run("R1", 3);
    // R5 and R2: small top, watch wraps and toggles
    wr_data = 16'd4; top_we = '1; step("R2");
    cnt_we = '1; wr_data = 16'd0; step("R10");
    run("R5", 20);
    // R3: prescale
    wr_data = 16'd2; pre_we = 3'b011; step("R3");
    run("R3", 40);
    // R6: enable interrupts
    opt_we = 1'b1; irq_en_in = 3'b111; ext_sel_in = '0; step("R6");
    run("R6", 20);
    // R7: clear timer 1 only, keep others
    irq_clr_we = 1'b1; irq_clr_mask = 3'b010; step("R7");
    run("R7", 4);
    irq_clr_we = 1'b1; irq_clr_mask = 3'b111; step("R7");
    // R8: drop enable of timer 0
    opt_we = 1'b1; irq_en_in = 3'b110; step("R8");
    run("R8", 10);
    // R4: external source on timers 0 and 1
    opt_we = 1'b1; irq_en_in = 3'b111; ext_sel_in = 2'b11; step("R4");
    wr_data = 16'd0; pre_we = 3'b011; step("R4");
    for (int k = 0; k < 60; k++) begin
      ext_clk = ext_clk ^ 2'(k % 3 == 0 ? 2'b01 : 2'b10);
      capt_we = 1'b1;
      step("R4");
    end
    // R10: counter load mid-prescale
    opt_we = 1'b1; ext_sel_in = '0; step("R10");
    wr_data = 16'd3; pre_we = '1; step("R10");
    run("R10", 2);
    wr_data = 16'd1; cnt_we = 3'b101; step("R10");
    run("R10", 12);
    // R9: capture only on command
    run("R9", 1);
    for (int k = 0; k < 8; k++) step("R9");
    // R11: any flag
    run("R11", 30);
    // constrained random
    for (int k = 0; k < 4000; k++) begin
      wr_data = 16'($urandom_range(0, 12));
      if ($urandom_range(0, 19) == 0) top_we = 3'($urandom());
      if ($urandom_range(0, 29) == 0) begin
        pre_we = 3'($urandom());
        wr_data = 16'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 39) == 0) cnt_we = 3'($urandom());
      if ($urandom_range(0, 49) == 0) begin
        opt_we = 1'b1; irq_en_in = 3'($urandom()); ext_sel_in = 2'($urandom());
      end
      if ($urandom_range(0, 9) == 0) begin
        irq_clr_we = 1'b1; irq_clr_mask = 3'($urandom());
      end
      capt_we = ($urandom_range(0, 3) == 0);
      ext_clk = 2'($urandom());
      step("R2");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule